// File: doc/BRIEF.md
# Crystal Clock Qualification and Switchover

This block decides when an external crystal may take over as the system clock. After power-on reset the chip runs from its internal oscillator. If the board strap says a crystal is fitted, the block counts crystal rising edges in the crystal's own clock domain. Once 1024 edges have been seen, it hands the system clock over to the crystal and then tells the internal oscillator to shut down. The handover is break-before-make: the internal clock enable drops first, a guard interval passes, and only then does the crystal clock enable rise. Neither enable changes in mid-pulse, because each is a flop clocked by the clock it gates.

A power-up timeout guards against a crystal that never starts. It is counted in ticks of a slow timebase. If the count reaches `TIMEOUT_TICKS` before qualification ends, the block disables the crystal circuit and stays on the internal oscillator. It remains in that failed state until the next power-on reset.

The controller has six states:
- `ST_IDLE`: no strap seen.
- `ST_QUALIFY`: counting crystal edges.
- `ST_DROP_INT`: internal enable is off; the guard interval runs.
- `ST_ENABLE_X`: the crystal enable has been requested and the block waits for its return.
- `ST_ON_XTAL`: terminal; running on the crystal.
- `ST_FAILED`: terminal; timeout expired.

The transitions are:
- IDLE→QUALIFY when the strap is high.
- QUALIFY→IDLE when the strap goes low.
- QUALIFY→DROP_INT when the count-reached flag arrives.
- IDLE or QUALIFY→FAILED when the timeout expires. The count-reached flag wins if both happen in the same cycle.
- DROP_INT→ENABLE_X after `GAP_CYCLES` cycles.
- ENABLE_X→ON_XTAL when the synchronised crystal enable is seen.

Top module: `xtal_qual_switch`

## Requirements
- R1: After power-on reset `int_clk_en`=1. All of `xtal_clk_en`, `clk_sel_xtal`, `int_osc_off`, `xtal_disable`, `stat_stable` and `stat_failed` are 0.
- R2: With `xtal_strap` low, the crystal is never qualified: `stat_stable` stays 0 and no switch happens, however long the crystal runs.
- R3: `stat_stable` rises only after at least 1024 crystal rising edges have occurred since the strap rose. It rises within a few further edges of synchronisation.
- R4: Pulling `xtal_strap` low during qualification clears the edge count. After the strap returns, a full 1024 new edges are needed.
- R5: Break-before-make: `int_clk_en` and `xtal_clk_en` are never both 1. `xtal_clk_en` rises no earlier than `GAP_CYCLES` internal cycles after `int_clk_en` falls.
- R6: Once the crystal enable is confirmed, `clk_sel_xtal`=1 and `int_osc_off`=1. Both stay set until power-on reset, even if the strap later drops.
- R7: If `TIMEOUT_TICKS` `slow_tick` pulses arrive before qualification completes, the block raises `xtal_disable`=1 and `stat_failed`=1. It keeps `int_clk_en`=1 and never switches. This holds with or without the strap.
- R8: The failed state persists until power-on reset, even if the crystal starts later. `stat_stable` stays 0 in it.
- R9: `stat_stable`, once set, stays set until power-on reset.
- R10: `slow_tick` pulses after qualification completes have no effect: no failure, and no return to the internal clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_int | input | 1 | Internal oscillator clock; the controller's clock |
| rst_n_por | input | 1 | Power-on reset, active low, asynchronous |
| clk_xtal | input | 1 | Crystal oscillator output |
| xtal_strap | input | 1 | High when a crystal is fitted (asynchronous) |
| slow_tick | input | 1 | One-cycle pulse in `clk_int` domain from the slow timebase |
| int_clk_en | output | 1 | Gate enable for the internal clock, registered on `clk_int` |
| xtal_clk_en | output | 1 | Gate enable for the crystal clock, registered on `clk_xtal` |
| clk_sel_xtal | output | 1 | System clock is now the crystal |
| int_osc_off | output | 1 | Request to shut down the internal oscillator |
| xtal_disable | output | 1 | Disable the crystal oscillator circuit |
| stat_stable | output | 1 | Status: crystal qualified |
| stat_failed | output | 1 | Status: crystal failed to start in time |

## Verification
Several properties are checked on every cycle:
- both gate enables never high together;
- the guard interval before the crystal enable is requested;
- the terminal states stay put, along with what they imply for the other outputs;
- the count-reached flag appears exactly at the terminal count.

The bench scenarios are needed for the rest, because these depend on stimulus history rather than on a single-cycle relation:
- the exact edge count needed before qualification;
- the clearing of the count by a strap drop;
- the timeout expiring with and without a strap;
- ticks and strap changes being ignored after commitment.

// File: rtl/xqs_pkg.sv
package xqs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_QUALIFY,
        ST_DROP_INT,
        ST_ENABLE_X,
        ST_ON_XTAL,
        ST_FAILED
    } xqs_state_e;

endpackage

// File: rtl/xqs_sync.sv
// Multi-stage flop synchroniser, one independent chain per bit.
module xqs_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/xqs_rst_sync.sv
// Asynchronous assert, synchronous release reset for a given clock.
module xqs_rst_sync (
    input  logic clk,
    input  logic arst_n,
    output logic srst_n
);
    logic [1:0] sh;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) sh <= 2'b00;
        else         sh <= {sh[0], 1'b1};
    end

    assign srst_n = sh[1];
endmodule

// File: rtl/xqs_xtal_side.sv
// Crystal-domain logic: edge counter and crystal clock gate enable.
module xqs_xtal_side #(
    parameter int XTAL_CYCLES = 1024
) (
    input  logic clk_xtal,
    input  logic rst_n_por,
    input  logic strap,
    input  logic xtal_req,
    output logic qual_done,
    output logic xtal_clk_en
);
    localparam int CW = $clog2(XTAL_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(XTAL_CYCLES - 1);

    logic          cnt_arst_n;
    logic          cnt_rst_n;
    logic          en_rst_n;
    logic [CW-1:0] cnt;
    logic          req_s;

    // strap low clears the count (and the done flag) asynchronously
    assign cnt_arst_n = rst_n_por & strap;

    xqs_rst_sync u_cnt_rst (.clk(clk_xtal), .arst_n(cnt_arst_n), .srst_n(cnt_rst_n));
    xqs_rst_sync u_en_rst  (.clk(clk_xtal), .arst_n(rst_n_por),  .srst_n(en_rst_n));

    always_ff @(posedge clk_xtal or negedge cnt_rst_n) begin
        if (!cnt_rst_n) begin
            cnt       <= '0;
            qual_done <= 1'b0;
        end else if (!qual_done) begin
            cnt <= cnt + 1'b1;
            if (cnt == LAST) qual_done <= 1'b1;
        end
    end

    xqs_sync #(.W(1), .STAGES(2)) u_req_sync (
        .clk(clk_xtal), .rst_n(en_rst_n), .d(xtal_req), .q(req_s)
    );

    always_ff @(posedge clk_xtal or negedge en_rst_n) begin
        if (!en_rst_n) xtal_clk_en <= 1'b0;
        else           xtal_clk_en <= req_s;
    end

    // R3: done appears exactly on the edge that completes the count
    assert_done_at_count_R3: assert property (@(posedge clk_xtal) disable iff (!cnt_rst_n)
        $rose(qual_done) |-> $past(cnt) == LAST);

    // R3: the counter never passes the qualification length
    assert_cnt_bound_R3: assert property (@(posedge clk_xtal) disable iff (!cnt_rst_n)
        cnt <= CW'(XTAL_CYCLES));
endmodule

// File: rtl/xqs_ctrl.sv
// Internal-domain controller: qualification, timeout and switchover handshake.
module xqs_ctrl
    import xqs_pkg::*;
#(
    parameter int TIMEOUT_TICKS = 10,
    parameter int GAP_CYCLES    = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strap_s,
    input  logic done_s,
    input  logic ack_s,
    input  logic slow_tick,
    output logic int_clk_en,
    output logic xtal_req,
    output logic clk_sel_xtal,
    output logic int_osc_off,
    output logic xtal_disable,
    output logic stat_stable,
    output logic stat_failed
);
    localparam int TW = $clog2(TIMEOUT_TICKS + 1);
    localparam int GW = $clog2(GAP_CYCLES + 1);

    xqs_state_e    state_q, state_d;
    logic [TW-1:0] tmo_cnt;
    logic [GW-1:0] gap_cnt;
    logic          tmo_hit;
    logic          gap_done;
    logic          pre_qual;

    assign pre_qual = (state_q == ST_IDLE) || (state_q == ST_QUALIFY);
    assign tmo_hit  = slow_tick && (tmo_cnt == TW'(TIMEOUT_TICKS - 1));
    assign gap_done = (gap_cnt == GW'(GAP_CYCLES - 1));

    // power-up timeout, counted in slow ticks until qualification ends
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   tmo_cnt <= '0;
        else if (pre_qual && slow_tick) tmo_cnt <= tmo_cnt + 1'b1;
    end

    // guard interval between dropping one enable and requesting the other
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      gap_cnt <= '0;
        else if (state_q == ST_DROP_INT) gap_cnt <= gap_cnt + 1'b1;
        else                             gap_cnt <= '0;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (tmo_hit)      state_d = ST_FAILED;
                else if (strap_s) state_d = ST_QUALIFY;
            end
            ST_QUALIFY: begin
                if (done_s)        state_d = ST_DROP_INT;
                else if (tmo_hit)  state_d = ST_FAILED;
                else if (!strap_s) state_d = ST_IDLE;
            end
            ST_DROP_INT: if (gap_done) state_d = ST_ENABLE_X;
            ST_ENABLE_X: if (ack_s)    state_d = ST_ON_XTAL;
            ST_ON_XTAL:  state_d = ST_ON_XTAL;
            ST_FAILED:   state_d = ST_FAILED;
            default:     state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // registered outputs, decoded from the next state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            int_clk_en   <= 1'b1;
            xtal_req     <= 1'b0;
            clk_sel_xtal <= 1'b0;
            int_osc_off  <= 1'b0;
            xtal_disable <= 1'b0;
            stat_stable  <= 1'b0;
            stat_failed  <= 1'b0;
        end else begin
            int_clk_en   <= (state_d == ST_IDLE) || (state_d == ST_QUALIFY)
                            || (state_d == ST_FAILED);
            xtal_req     <= (state_d == ST_ENABLE_X) || (state_d == ST_ON_XTAL);
            clk_sel_xtal <= (state_d == ST_ON_XTAL);
            int_osc_off  <= (state_d == ST_ON_XTAL);
            xtal_disable <= (state_d == ST_FAILED);
            stat_stable  <= (state_d == ST_DROP_INT) || (state_d == ST_ENABLE_X)
                            || (state_d == ST_ON_XTAL);
            stat_failed  <= (state_d == ST_FAILED);
        end
    end

    // R5: crystal request only after the internal enable was already low a cycle
    assert_gap_before_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xtal_req) |-> (!int_clk_en && $past(!int_clk_en)));

    // R6: the switch is permanent and implies the internal clock is off
    assert_sel_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clk_sel_xtal |=> clk_sel_xtal);
    assert_sel_implies_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clk_sel_xtal |-> (int_osc_off && !int_clk_en));

    // R7: a failed crystal never takes the clock
    assert_fail_no_switch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        stat_failed |-> (int_clk_en && xtal_disable && !xtal_req && !stat_stable));

    // R8: failure persists
    assert_fail_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        stat_failed |=> stat_failed);

    // R9: qualification persists
    assert_stable_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stat_stable |=> stat_stable);
endmodule

// File: rtl/xtal_qual_switch.sv
// Top: crystal qualification and glitch-free switchover.
module xtal_qual_switch #(
    parameter int XTAL_CYCLES   = 1024,
    parameter int TIMEOUT_TICKS = 10,
    parameter int GAP_CYCLES    = 2,
    parameter int SYNC_STAGES   = 2
) (
    input  logic clk_int,
    input  logic rst_n_por,
    input  logic clk_xtal,
    input  logic xtal_strap,
    input  logic slow_tick,
    output logic int_clk_en,
    output logic xtal_clk_en,
    output logic clk_sel_xtal,
    output logic int_osc_off,
    output logic xtal_disable,
    output logic stat_stable,
    output logic stat_failed
);
    logic qual_done;
    logic xtal_req;
    logic strap_s, done_s, ack_s;

    xqs_xtal_side #(.XTAL_CYCLES(XTAL_CYCLES)) u_xtal (
        .clk_xtal   (clk_xtal),
        .rst_n_por  (rst_n_por),
        .strap      (xtal_strap),
        .xtal_req   (xtal_req),
        .qual_done  (qual_done),
        .xtal_clk_en(xtal_clk_en)
    );

    // strap, count-reached and enable-acknowledge into the internal domain
    xqs_sync #(.W(3), .STAGES(SYNC_STAGES)) u_int_sync (
        .clk  (clk_int),
        .rst_n(rst_n_por),
        .d    ({xtal_strap, qual_done, xtal_clk_en}),
        .q    ({strap_s, done_s, ack_s})
    );

    xqs_ctrl #(.TIMEOUT_TICKS(TIMEOUT_TICKS), .GAP_CYCLES(GAP_CYCLES)) u_ctrl (
        .clk         (clk_int),
        .rst_n       (rst_n_por),
        .strap_s     (strap_s),
        .done_s      (done_s),
        .ack_s       (ack_s),
        .slow_tick   (slow_tick),
        .int_clk_en  (int_clk_en),
        .xtal_req    (xtal_req),
        .clk_sel_xtal(clk_sel_xtal),
        .int_osc_off (int_osc_off),
        .xtal_disable(xtal_disable),
        .stat_stable (stat_stable),
        .stat_failed (stat_failed)
    );

    // R5: the two gate enables are never on together
    assert_break_before_make_R5: assert property (@(posedge clk_int) disable iff (!rst_n_por)
        !(int_clk_en && xtal_clk_en));
endmodule

// File: tb/test_xtal_qual_switch.sv
module test_xtal_qual_switch;
    localparam int GAP = 2;

    logic clk = 1'b0;
    logic clk_xtal = 1'b0;
    logic rst_n = 1'b0;
    logic strap = 1'b0;
    logic xrun = 1'b0;
    logic tick = 1'b0;
    logic int_clk_en, xtal_clk_en, clk_sel_xtal, int_osc_off;
    logic xtal_disable, stat_stable, stat_failed;

    int total = 0;
    int bad = 0;
    int xedges = 0;
    int cyc = 0;
    int overlap = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;
    always #13 clk_xtal = xrun ? ~clk_xtal : 1'b0;
    always @(posedge clk_xtal) xedges++;
    always @(posedge clk) cyc++;
    always @(negedge clk) if (rst_n && int_clk_en && xtal_clk_en) overlap++;

    xtal_qual_switch #(.XTAL_CYCLES(1024), .TIMEOUT_TICKS(10), .GAP_CYCLES(GAP)) i_xtal_qual_switch (
        .clk_int(clk), .rst_n_por(rst_n), .clk_xtal(clk_xtal), .xtal_strap(strap),
        .slow_tick(tick), .int_clk_en(int_clk_en), .xtal_clk_en(xtal_clk_en),
        .clk_sel_xtal(clk_sel_xtal), .int_osc_off(int_osc_off),
        .xtal_disable(xtal_disable), .stat_stable(stat_stable), .stat_failed(stat_failed)
    );

    // {strap, crystal runs, ticks[4:0], exp stable, exp failed, exp switched}
    localparam int NV = 6;
    localparam logic [9:0] VEC [NV] = '{
        {1'b1, 1'b1, 5'd0,  1'b1, 1'b0, 1'b1},   // R3 R6 normal qualification
        {1'b1, 1'b0, 5'd10, 1'b0, 1'b1, 1'b0},   // R7 dead crystal
        {1'b0, 1'b1, 5'd0,  1'b0, 1'b0, 1'b0},   // R2 no strap
        {1'b0, 1'b1, 5'd10, 1'b0, 1'b1, 1'b0},   // R7 timeout without strap
        {1'b1, 1'b1, 5'd9,  1'b1, 1'b0, 1'b1},   // R7 one tick short
        {1'b1, 1'b0, 5'd9,  1'b0, 1'b0, 1'b0}    // R7 one tick short, dead
    };

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic por();
        rst_n = 1'b0; strap = 1'b0; xrun = 1'b0; tick = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic send_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tick = 1'b1;
            @(negedge clk) tick = 1'b0;
            repeat (3) @(negedge clk);
        end
    endtask

    task automatic wait_edges(input int n);
        while (xedges < n) @(negedge clk);
    endtask

    task automatic wait_sig(ref logic s, input int lim);
        for (int i = 0; i < lim && s !== 1'b1; i++) @(negedge clk);
    endtask

    initial begin
        int e, fall_cyc, rise_cyc;
        // R1 reset state
        por();
        chk("R1 int_clk_en", int_clk_en, 1);
        chk("R1 xtal_clk_en", xtal_clk_en, 0);
        chk("R1 clk_sel_xtal", clk_sel_xtal, 0);
        chk("R1 int_osc_off", int_osc_off, 0);
        chk("R1 xtal_disable", xtal_disable, 0);
        chk("R1 stat_stable", stat_stable, 0);
        chk("R1 stat_failed", stat_failed, 0);

        // table of scenarios
        for (int v = 0; v < NV; v++) begin
            por();
            strap = VEC[v][9];
            xrun  = VEC[v][8];
            send_ticks(int'(VEC[v][7:3]));
            repeat (4000) @(negedge clk);
            chk($sformatf("R7 vec%0d stable", v), stat_stable, int'(VEC[v][2]));
            chk($sformatf("R7 vec%0d failed", v), stat_failed, int'(VEC[v][1]));
            chk($sformatf("R6 vec%0d sel", v), clk_sel_xtal, int'(VEC[v][0]));
            chk($sformatf("R6 vec%0d osc_off", v), int_osc_off, int'(VEC[v][0]));
            chk($sformatf("R7 vec%0d xtal_disable", v), xtal_disable, int'(VEC[v][1]));
            chk($sformatf("R5 vec%0d int_clk_en", v), int_clk_en, int'(!VEC[v][0]));
        end

        // R3 exact count boundary and R5 handover timing
        por();
        strap = 1'b1;
        xedges = 0;
        xrun = 1'b1;
        wait_edges(1000);
        chk("R3 not stable at 1000 edges", stat_stable, 0);
        chk("R3 int clock kept at 1000 edges", int_clk_en, 1);
        wait_sig(stat_stable, 500);
        e = xedges;
        chk($sformatf("R3 stable after %0d edges in [1024,1040]", e), int'(e >= 1024 && e <= 1040), 1);
        chk("R5 int enable dropped with stable", int_clk_en, 0);
        fall_cyc = cyc;
        wait_sig(xtal_clk_en, 200);
        rise_cyc = cyc;
        chk("R5 xtal enable rises", xtal_clk_en, 1);
        chk($sformatf("R5 guard gap %0d", rise_cyc - fall_cyc), int'(rise_cyc - fall_cyc >= GAP), 1);
        wait_sig(clk_sel_xtal, 100);
        chk("R6 switched", clk_sel_xtal, 1);
        chk("R6 osc off", int_osc_off, 1);

        // R10 ticks after qualification are ignored
        send_ticks(20);
        repeat (20) @(negedge clk);
        chk("R10 no failure after switch", stat_failed, 0);
        chk("R10 still on crystal", clk_sel_xtal, 1);
        chk("R9 stable kept", stat_stable, 1);

        // R6 strap drop after commitment is ignored
        strap = 1'b0;
        repeat (50) @(negedge clk);
        chk("R6 sel kept after strap low", clk_sel_xtal, 1);
        chk("R6 xtal enable kept after strap low", xtal_clk_en, 1);

        // R4 strap drop mid-qualification restarts the count
        por();
        strap = 1'b1;
        xedges = 0;
        xrun = 1'b1;
        wait_edges(800);
        strap = 1'b0;
        repeat (20) @(negedge clk);
        strap = 1'b1;
        xedges = 0;
        wait_edges(1000);
        chk("R4 not stable 1000 edges after restart", stat_stable, 0);
        wait_sig(stat_stable, 500);
        e = xedges;
        chk($sformatf("R4 stable after %0d new edges", e), int'(e >= 1024 && e <= 1040), 1);

        // R8 failure survives a crystal that starts late
        por();
        strap = 1'b1;
        send_ticks(10);
        repeat (5) @(negedge clk);
        chk("R7 failed after timeout", stat_failed, 1);
        xrun = 1'b1;
        repeat (4000) @(negedge clk);
        chk("R8 still failed", stat_failed, 1);
        chk("R8 not stable", stat_stable, 0);
        chk("R8 no switch", clk_sel_xtal, 0);
        chk("R8 xtal disabled", xtal_disable, 1);

        chk("R5 enables never overlapped", overlap, 0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog R1 actual=%0d expected=%0d", cyc, 150000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule